// File: doc/BRIEF.md
# Rename Stage Stall and Skid Controller

This block is the control path of one thread's register-rename stage. Each cycle it may receive a group of up to `GW` instructions from decode. Each lane carries a valid bit, a kill bit, two serialization flags and a payload tag. When nothing holds the stage back, it forwards the live instructions to a row of downstream slots. When a later stage stalls it, it parks the incoming group in an internal skid buffer and tells decode to stop sending. It later drains that buffer, oldest first, before it takes fresh input again.

The controller also handles serialization. An instruction flagged "serialize before" is held back until the reorder buffer is empty and nothing is still in flight toward it. An instruction flagged "serialize after" makes its successor wait in the same way. A squash from the back end discards everything the stage holds. The register mapping itself, any event counting and the arbitration between threads are outside this block. The skid buffer holds `2*BE_DELAY*GW + GW` entries, which is enough to absorb every group still in flight while the back-end stall signal travels.

Top module: `rn_stall_ctrl`

## Requirements
- R1: After reset the state output is Idle, no output slot is valid, and neither dec_block nor dec_unblock is asserted.
- R2: state_o encodes Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4 and SerStall=5. Each cycle the first matching case wins, in this order: squash, ROB still squashing, stall, Blocked, Squashing, SerStall, rename.
- R3: In Idle or Running with no stall, the live lanes (valid and not killed) are sent to the output slots on the next cycle. They are packed into slots 0 upward in lane order, and killed lanes take no slot. The first live group moves Idle to Running.
- R4: A stall_set pulse latches a stall and a stall_clr pulse clears it; when both arrive in the same cycle, the clear wins. While the stall is in effect, live inputs are appended to the skid buffer and the state becomes Blocked, except that SerStall is kept. dec_block pulses for one cycle only when the stall is entered from Idle, Running or Squashing.
- R5: With the stall gone, Blocked moves to Unblocking one cycle later without emitting. In Unblocking, up to GW of the oldest skid entries are sent per cycle, and live decode inputs are appended behind them.
- R6: In the cycle in which Unblocking empties the skid buffer without meeting a serializing instruction, the state returns to Running and dec_unblock pulses for one cycle.
- R7: A candidate with its serialize-before flag (lane bit dec_sb) set is not emitted. It is held, and neither it nor any later candidate of that cycle is sent. Later decode lanes move to the skid buffer, while later skid entries stay in place. The state becomes SerStall, and dec_block pulses if this happened in Idle or Running.
- R8: SerStall persists while rob_empty is 0, inflight is non-zero or the stall is in effect. When it ends, the held instruction has its serialize-before flag cleared and is placed at the head of the skid buffer, and the state becomes Unblocking.
- R9: An emitted instruction with its serialize-after flag (dec_sa) set makes the next candidate of the same cycle act as serialize-before. If no candidate follows it, a sticky flag marks the first candidate of a later rename cycle instead. The flag is dropped when a rename cycle sees rob_empty=1 with inflight=0.
- R10: squash_in clears the skid buffer, the held instruction and the sticky flag, drops the current inputs and enters Squashing. dec_unblock pulses if the state was Blocked, Unblocking or SerStall.
- R11: rob_squashing (without squash_in) enters Squashing and drops the inputs. From Squashing, with neither squash nor stall, the state moves to Running the next cycle without emitting.
- R12: The number of skid entries never exceeds 2*BE_DELAY*GW + GW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_vld | input | GW | Lane valid from decode |
| dec_kill | input | GW | Lane already squashed; dropped |
| dec_sb | input | GW | Lane must serialize before |
| dec_sa | input | GW | Lane serializes the one after it |
| dec_data | input | GW*DW | Lane payload tags, lane 0 in the low bits |
| stall_set | input | 1 | Back-end stall pulse |
| stall_clr | input | 1 | Back-end stall release pulse |
| squash_in | input | 1 | Squash this thread |
| rob_squashing | input | 1 | Reorder buffer still squashing |
| rob_empty | input | 1 | Reorder buffer is empty |
| inflight | input | IFW | Instructions between rename and the reorder buffer |
| out_vld | output | GW | Downstream slot valid |
| out_data | output | GW*DW | Downstream slot payloads |
| dec_block | output | 1 | One-cycle block request to decode |
| dec_unblock | output | 1 | One-cycle unblock notice to decode |
| state_o | output | 3 | Current state, encoded as in R2 |

## Verification
On every cycle the assertions check the following. Block and unblock are never asserted together. Block appears only with a Blocked or SerStall state, and unblock only with Running or Squashing. A squash or ROB-squash lands the state in Squashing with empty slots. SerStall cannot be left while the ROB is busy. Valid slots are always packed from slot 0. The skid buffer never overflows. Only the bench's scenarios can show that the correct instructions leave, in the correct order. These include the drain order through the skid buffer, a held instruction re-entering at the head, and the sticky serialize mark landing on the right later instruction. The bench checks them against its own queue model for each cycle.

// File: rtl/rn_pkg.sv
package rn_pkg;

   typedef enum logic [2:0] {
      RS_IDLE = 3'd0,
      RS_RUN  = 3'd1,
      RS_BLK  = 3'd2,
      RS_UNB  = 3'd3,
      RS_SQ   = 3'd4,
      RS_SER  = 3'd5
   } rn_state_e;

   // skid capacity: groups in flight during the stall round trip plus one group
   function automatic int skid_depth(input int gw, input int dly);
      return 2 * dly * gw + gw;
   endfunction

endpackage

// File: rtl/rn_compact.sv
module rn_compact #(
   parameter int GW = 4,
   parameter int EW = 10
) (
   input  logic [GW-1:0]         vld_i,
   input  logic [GW-1:0][EW-1:0] ent_i,
   output logic [GW-1:0]         vld_o,
   output logic [GW-1:0][EW-1:0] ent_o
);

   always_comb begin
      int k;
      k     = 0;
      vld_o = '0;
      ent_o = '0;
      for (int i = 0; i < GW; i++) begin
         if (vld_i[i]) begin
            vld_o[k] = 1'b1;
            ent_o[k] = ent_i[i];
            k++;
         end
      end
   end

endmodule

// File: rtl/rn_walk.sv
module rn_walk #(
   parameter int GW = 4,
   parameter int DW = 8,
   localparam int EW = DW + 2,
   localparam int PW = $clog2(GW + 1)
) (
   input  logic [GW-1:0]         cvld_i,
   input  logic [GW-1:0][EW-1:0] cent_i,
   input  logic                  mark_i,
   output logic [GW-1:0]         evld_o,
   output logic [GW-1:0][DW-1:0] edat_o,
   output logic                  hold_o,
   output logic [EW-1:0]         hold_ent_o,
   output logic [PW-1:0]         used_o,
   output logic                  any_o,
   output logic                  sticky_set_o
);

   always_comb begin
      logic mark;
      logic stop;
      mark         = mark_i;
      stop         = 1'b0;
      evld_o       = '0;
      edat_o       = '0;
      hold_o       = 1'b0;
      hold_ent_o   = '0;
      used_o       = '0;
      any_o        = cvld_i[0];
      for (int i = 0; i < GW; i++) begin
         if (cvld_i[i] && !stop) begin
            used_o = PW'(i + 1);
            if (cent_i[i][DW] || mark) begin
               hold_o     = 1'b1;
               hold_ent_o = cent_i[i];
               stop       = 1'b1;
            end else begin
               evld_o[i] = 1'b1;
               edat_o[i] = cent_i[i][DW-1:0];
               mark      = cent_i[i][DW+1];
            end
         end
      end
      sticky_set_o = any_o && !stop && mark;
   end

endmodule

// File: rtl/rn_skid.sv
module rn_skid #(
   parameter int DEPTH = 12,
   parameter int EW    = 10,
   parameter int GW    = 4,
   localparam int CW   = $clog2(DEPTH + 1),
   localparam int PW   = $clog2(GW + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr_i,
   input  logic                  front_vld_i,
   input  logic [EW-1:0]         front_ent_i,
   input  logic [PW-1:0]         pop_i,
   input  logic [GW-1:0]         push_vld_i,
   input  logic [GW-1:0][EW-1:0] push_ent_i,
   output logic [CW-1:0]         cnt_o,
   output logic [GW-1:0][EW-1:0] head_o,
   output logic                  ovf_o
);

   logic [DEPTH-1:0][EW-1:0] mem_q, mem_d;
   logic [CW-1:0]            cnt_q, cnt_d;

   always_comb begin
      int f, rem, k, total, src;
      f     = front_vld_i ? 1 : 0;
      rem   = int'(cnt_q) - int'(pop_i);
      if (rem < 0) rem = 0;
      mem_d = '0;
      for (int i = 0; i < DEPTH; i++) begin
         src = i - f + int'(pop_i);
         if (f == 1 && i == 0) mem_d[i] = front_ent_i;
         else if (i - f < rem && src < DEPTH) mem_d[i] = mem_q[src];
      end
      k = 0;
      for (int p = 0; p < GW; p++) begin
         if (push_vld_i[p]) begin
            if (f + rem + k < DEPTH) mem_d[f + rem + k] = push_ent_i[p];
            k++;
         end
      end
      total = f + rem + k;
      ovf_o = total > DEPTH;
      cnt_d = ovf_o ? CW'(DEPTH) : CW'(total);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) begin
         mem_q <= '0;
         cnt_q <= '0;
      end else begin
         mem_q <= mem_d;
         cnt_q <= cnt_d;
      end
   end

   assign cnt_o = cnt_q;

   for (genvar g = 0; g < GW; g++) begin : g_head
      assign head_o[g] = mem_q[g];
   end

endmodule

// File: rtl/rn_stall_ctrl.sv
module rn_stall_ctrl
   import rn_pkg::*;
#(
   parameter int GW       = 4,
   parameter int DW       = 8,
   parameter int BE_DELAY = 1,
   parameter int IFW      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [GW-1:0]     dec_vld,
   input  logic [GW-1:0]     dec_kill,
   input  logic [GW-1:0]     dec_sb,
   input  logic [GW-1:0]     dec_sa,
   input  logic [GW*DW-1:0]  dec_data,
   input  logic              stall_set,
   input  logic              stall_clr,
   input  logic              squash_in,
   input  logic              rob_squashing,
   input  logic              rob_empty,
   input  logic [IFW-1:0]    inflight,
   output logic [GW-1:0]     out_vld,
   output logic [GW*DW-1:0]  out_data,
   output logic              dec_block,
   output logic              dec_unblock,
   output logic [2:0]        state_o
);

   localparam int EW    = DW + 2;
   localparam int DEPTH = skid_depth(GW, BE_DELAY);
   localparam int CW    = $clog2(DEPTH + 1);
   localparam int PW    = $clog2(GW + 1);

   if (GW < 2)       begin : g_bad_gw  $error("GW must be at least 2");       end
   if (DW < 1)       begin : g_bad_dw  $error("DW must be at least 1");       end
   if (BE_DELAY < 1) begin : g_bad_dly $error("BE_DELAY must be at least 1"); end
   if (IFW < 1)      begin : g_bad_ifw $error("IFW must be at least 1");      end

   rn_state_e            st_q, st_d;
   logic                 stall_q, stall_now, stall_eff, rob_idle;
   logic                 sticky_q, sticky_d, mark_in;
   logic [EW-1:0]        held_q, held_d;

   logic [GW-1:0]          raw_vld, lv;
   logic [GW-1:0][EW-1:0]  raw_ent, le;

   logic                  sk_clr, f_vld;
   logic [EW-1:0]         f_ent;
   logic [PW-1:0]         pop_n;
   logic [GW-1:0]         push_m;
   logic [CW-1:0]         sk_cnt;
   logic [GW-1:0][EW-1:0] sk_head;
   logic                  skid_ovf;

   logic [GW-1:0]         cvld, head_vld, rem_mask;
   logic [GW-1:0][EW-1:0] cent;
   logic [GW-1:0]         w_evld;
   logic [GW-1:0][DW-1:0] w_edat;
   logic                  w_hold, w_any, w_sset;
   logic [EW-1:0]         w_hold_ent;
   logic [PW-1:0]         w_used;

   logic [GW-1:0]         emit_d;
   logic                  blk_d, ublk_d;

   // lane packing: {sa, sb, data}
   for (genvar g = 0; g < GW; g++) begin : g_lane
      assign raw_ent[g]  = {dec_sa[g], dec_sb[g], dec_data[g*DW +: DW]};
      assign head_vld[g] = int'(sk_cnt) > g;
      assign rem_mask[g] = g >= int'(w_used);
   end
   assign raw_vld = dec_vld & ~dec_kill;

   rn_compact #(.GW(GW), .EW(EW)) u_compact (
      .vld_i (raw_vld),
      .ent_i (raw_ent),
      .vld_o (lv),
      .ent_o (le)
   );

   assign stall_now = (stall_q | stall_set) & ~stall_clr;
   assign rob_idle  = rob_empty && (inflight == '0);
   assign stall_eff = stall_now || ((st_q == RS_SER) && !rob_idle);
   assign mark_in   = sticky_q && !rob_idle;

   assign cvld = (st_q == RS_UNB) ? head_vld : lv;
   assign cent = (st_q == RS_UNB) ? sk_head  : le;

   rn_walk #(.GW(GW), .DW(DW)) u_walk (
      .cvld_i       (cvld),
      .cent_i       (cent),
      .mark_i       (mark_in),
      .evld_o       (w_evld),
      .edat_o       (w_edat),
      .hold_o       (w_hold),
      .hold_ent_o   (w_hold_ent),
      .used_o       (w_used),
      .any_o        (w_any),
      .sticky_set_o (w_sset)
   );

   assign f_ent = {held_q[EW-1], 1'b0, held_q[DW-1:0]};

   rn_skid #(.DEPTH(DEPTH), .EW(EW), .GW(GW)) u_skid (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (sk_clr),
      .front_vld_i (f_vld),
      .front_ent_i (f_ent),
      .pop_i       (pop_n),
      .push_vld_i  (push_m),
      .push_ent_i  (le),
      .cnt_o       (sk_cnt),
      .head_o      (sk_head),
      .ovf_o       (skid_ovf)
   );

   always_comb begin
      st_d     = st_q;
      blk_d    = 1'b0;
      ublk_d   = 1'b0;
      sk_clr   = 1'b0;
      f_vld    = 1'b0;
      pop_n    = '0;
      push_m   = '0;
      emit_d   = '0;
      held_d   = held_q;
      sticky_d = sticky_q;
      if (squash_in) begin
         sk_clr   = 1'b1;
         sticky_d = 1'b0;
         held_d   = '0;
         ublk_d   = (st_q == RS_BLK) || (st_q == RS_UNB) || (st_q == RS_SER);
         st_d     = RS_SQ;
      end else if (rob_squashing) begin
         st_d = RS_SQ;
      end else if (stall_eff) begin
         push_m = lv;
         blk_d  = (st_q == RS_IDLE) || (st_q == RS_RUN) || (st_q == RS_SQ);
         st_d   = (st_q == RS_SER) ? RS_SER : RS_BLK;
      end else begin
         case (st_q)
            RS_BLK: begin
               push_m = lv;
               st_d   = RS_UNB;
            end
            RS_SQ: st_d = RS_RUN;
            RS_SER: begin
               f_vld  = 1'b1;
               push_m = lv;
               st_d   = RS_UNB;
            end
            default: begin
               sticky_d = mark_in;
               if (w_any)  sticky_d = 1'b0;
               if (w_sset) sticky_d = 1'b1;
               emit_d = w_evld;
               if (st_q == RS_UNB) begin
                  pop_n  = w_used;
                  push_m = lv;
                  if (w_hold) begin
                     held_d = w_hold_ent;
                     st_d   = RS_SER;
                  end else if (int'(w_used) == int'(sk_cnt) && lv == '0) begin
                     st_d   = RS_RUN;
                     ublk_d = 1'b1;
                  end
               end else if (w_hold) begin
                  held_d = w_hold_ent;
                  push_m = lv & rem_mask;
                  blk_d  = 1'b1;
                  st_d   = RS_SER;
               end else if (|lv) begin
                  st_d = RS_RUN;
               end
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q        <= RS_IDLE;
         stall_q     <= 1'b0;
         sticky_q    <= 1'b0;
         held_q      <= '0;
         out_vld     <= '0;
         out_data    <= '0;
         dec_block   <= 1'b0;
         dec_unblock <= 1'b0;
      end else begin
         st_q        <= st_d;
         stall_q     <= stall_now;
         sticky_q    <= sticky_d;
         held_q      <= held_d;
         out_vld     <= emit_d;
         out_data    <= w_edat;
         dec_block   <= blk_d;
         dec_unblock <= ublk_d;
      end
   end

   assign state_o = st_q;

endmodule

// File: rtl/rn_stall_ctrl_chk.sv
module rn_stall_ctrl_chk #(
   parameter int GW  = 4,
   parameter int IFW = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           squash_in,
   input logic           rob_squashing,
   input logic           rob_empty,
   input logic [IFW-1:0] inflight,
   input logic [GW-1:0]  out_vld,
   input logic           dec_block,
   input logic           dec_unblock,
   input logic [2:0]     state_o,
   input logic           skid_ovf
);

   // R12
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !skid_ovf);

   // R4
   blk_unblk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(dec_block && dec_unblock));

   // R4
   block_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_block |-> (state_o == 3'd2 || state_o == 3'd5));

   // R6
   unblock_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_unblock |-> (state_o == 3'd1 || state_o == 3'd4));

   // R10
   squash_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      squash_in |=> (state_o == 3'd4 && out_vld == '0));

   // R11
   robsq_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rob_squashing && !squash_in) |=> (state_o == 3'd4 && out_vld == '0));

   // R8
   ser_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_o == 3'd5 && (!rob_empty || inflight != '0) && !squash_in && !rob_squashing)
      |=> state_o == 3'd5);

   // R3
   slots_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_vld & (out_vld + 1'b1)) == '0);

endmodule

bind rn_stall_ctrl rn_stall_ctrl_chk #(.GW(GW), .IFW(IFW)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .squash_in     (squash_in),
   .rob_squashing (rob_squashing),
   .rob_empty     (rob_empty),
   .inflight      (inflight),
   .out_vld       (out_vld),
   .dec_block     (dec_block),
   .dec_unblock   (dec_unblock),
   .state_o       (state_o),
   .skid_ovf      (skid_ovf)
);

// File: tb/rn_stall_ctrl_test.sv
`timescale 1ns/1ps
module rn_stall_ctrl_test;
   localparam int GW = 4, DW = 8, DLY = 1, IFW = 4;
   localparam int CAP = 2 * DLY * GW + GW;
   localparam int NCYC = 4000;

   typedef struct packed { logic sa; logic sb; logic [DW-1:0] d; } tent_t;

   logic clk = 0, rst_n = 0;
   logic [GW-1:0] dec_vld = '0, dec_kill = '0, dec_sb = '0, dec_sa = '0;
   logic [GW*DW-1:0] dec_data = '0;
   logic stall_set = 0, stall_clr = 0, squash_in = 0, rob_squashing = 0, rob_empty = 1;
   logic [IFW-1:0] inflight = '0;
   logic [GW-1:0] out_vld;
   logic [GW*DW-1:0] out_data;
   logic dec_block, dec_unblock;
   logic [2:0] state_o;

   rn_stall_ctrl #(.GW(GW), .DW(DW), .BE_DELAY(DLY), .IFW(IFW)) uut (.*);

   always #2.5 clk = ~clk;

   int n_chk = 0, n_fail = 0, max_skid = 0;
   bit done = 0;

   // reference model state
   int    m_st = 0;
   tent_t m_skid[$];
   tent_t m_held;
   bit    m_sticky = 0, m_stall = 0;
   // expected registered outputs
   bit [GW-1:0] e_vld;
   logic [DW-1:0] e_dat[GW];
   bit e_blk, e_ublk;
   int e_st;
   string e_tag;

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   // one cycle of the requirement model, from the inputs now on the pins
   task automatic model_step();
      tent_t l[$], c[$];
      bit stall_now, ridle, eff, mark, hold;
      int used;
      e_vld = '0; e_blk = 0; e_ublk = 0;
      for (int g = 0; g < GW; g++) e_dat[g] = '0;
      for (int g = 0; g < GW; g++)
         if (dec_vld[g] && !dec_kill[g]) l.push_back({dec_sa[g], dec_sb[g], dec_data[g*DW +: DW]});
      stall_now = (m_stall | stall_set) & ~stall_clr;
      m_stall   = stall_now;
      ridle     = rob_empty && (inflight == 0);
      eff       = stall_now || (m_st == 5 && !ridle);
      if (squash_in) begin
         e_ublk = (m_st == 2 || m_st == 3 || m_st == 5);
         m_skid.delete(); m_held = '0; m_sticky = 0; m_st = 4; e_tag = "R10";
      end else if (rob_squashing) begin
         m_st = 4; e_tag = "R11";
      end else if (eff) begin
         foreach (l[i]) m_skid.push_back(l[i]);
         e_blk = (m_st == 0 || m_st == 1 || m_st == 4);
         e_tag = (m_st == 5) ? "R8" : "R4";
         m_st  = (m_st == 5) ? 5 : 2;
      end else if (m_st == 2) begin
         foreach (l[i]) m_skid.push_back(l[i]);
         m_st = 3; e_tag = "R5";
      end else if (m_st == 4) begin
         m_st = 1; e_tag = "R11";
      end else if (m_st == 5) begin
         tent_t h;
         h = m_held; h.sb = 0;
         m_skid.push_front(h);
         foreach (l[i]) m_skid.push_back(l[i]);
         m_st = 3; e_tag = "R8";
      end else begin
         mark = m_sticky && !ridle;
         m_sticky = mark;
         e_tag = (m_st == 3) ? "R5" : "R3";
         if (mark) e_tag = "R9";
         if (m_st == 3) begin
            for (int i = 0; i < GW && i < m_skid.size(); i++) c.push_back(m_skid[i]);
         end else c = l;
         if (c.size() > 0) m_sticky = 0;
         hold = 0; used = 0;
         foreach (c[i]) begin
            if (!hold) begin
               used = i + 1;
               if (c[i].sb || mark) begin
                  hold = 1; m_held = c[i]; e_tag = "R7";
               end else begin
                  e_vld[i] = 1; e_dat[i] = c[i].d; mark = c[i].sa;
                  if (mark) e_tag = "R9";
               end
            end
         end
         if (!hold && mark && c.size() > 0) m_sticky = 1;
         if (m_st == 3) begin
            for (int i = 0; i < used; i++) void'(m_skid.pop_front());
            foreach (l[i]) m_skid.push_back(l[i]);
            if (hold) m_st = 5;
            else if (m_skid.size() == 0) begin m_st = 1; e_ublk = 1; e_tag = "R6"; end
         end else if (hold) begin
            for (int i = used; i < l.size(); i++) m_skid.push_back(l[i]);
            e_blk = 1; m_st = 5;
         end else if (l.size() > 0) m_st = 1;
      end
      if (m_skid.size() > max_skid) max_skid = m_skid.size();
      e_st = m_st;
   endtask

   initial begin
      bit dhold, prev_sq;
      int x;
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(state_o == 3'd0, "R1", "reset state", int'(state_o), 0);
      chk(out_vld == '0, "R1", "reset slots", int'(out_vld), 0);
      chk(!dec_block && !dec_unblock, "R1", "reset handshakes", int'({dec_block, dec_unblock}), 0);
      rst_n = 1;
      dhold = 0; prev_sq = 0;
      e_vld = '0; e_blk = 0; e_ublk = 0; e_st = 0; e_tag = "R1";
      for (int cyc = 0; cyc < NCYC; cyc++) begin
         @(negedge clk);
         if (cyc > 0) begin
            chk(int'(state_o) == e_st, "R2", e_tag, int'(state_o), e_st);
            chk(out_vld == e_vld, e_tag, "slot valid", int'(out_vld), int'(e_vld));
            for (int g = 0; g < GW; g++)
               if (e_vld[g]) chk(out_data[g*DW +: DW] == e_dat[g], e_tag, "slot data",
                                 int'(out_data[g*DW +: DW]), int'(e_dat[g]));
            chk(dec_block == e_blk, e_tag, "block", int'(dec_block), int'(e_blk));
            chk(dec_unblock == e_ublk, e_tag, "unblock", int'(dec_unblock), int'(e_ublk));
         end
         if (dec_block) dhold = 1;
         if (dec_unblock) dhold = 0;
         // random stimulus
         dec_vld = '0; dec_kill = '0; dec_sb = '0; dec_sa = '0;
         for (int g = 0; g < GW; g++) begin
            dec_data[g*DW +: DW] = DW'($urandom);
            if (!dhold) begin
               dec_vld[g] = ($urandom % 4) != 0;
               dec_kill[g] = ($urandom % 8) == 0;
               x = $urandom % 16;
               dec_sb[g] = (x == 0);
               dec_sa[g] = (x == 1);
            end
         end
         stall_set = ($urandom % 20) == 0;
         stall_clr = m_stall && (($urandom % 4) == 0);
         squash_in = ($urandom % 60) == 0;
         rob_squashing = prev_sq && ($urandom % 2);
         rob_empty = ($urandom % 2);
         inflight = ($urandom % 2) ? '0 : IFW'($urandom % 4);
         // directed corners
         if (cyc == 5 && !dhold) begin      // R9: sa on the last lane, sticky into next group
            dec_vld = '1; dec_kill = '0; dec_sb = '0; dec_sa = 4'b1000;
            stall_set = 0; squash_in = 0; rob_squashing = 0; rob_empty = 0;
         end
         if (cyc == 6) begin
            stall_set = 0; squash_in = 0; rob_squashing = 0; rob_empty = 0;
         end
         if (cyc == 20 && !dhold) begin     // R7: sb mid-group, ROB busy
            dec_vld = '1; dec_kill = '0; dec_sb = 4'b0010; dec_sa = '0;
            stall_set = 0; squash_in = 0; rob_squashing = 0;
         end
         if (cyc >= 20 && cyc < 25) begin rob_empty = 0; squash_in = 0; rob_squashing = 0; end
         if (cyc == 40) begin stall_set = 1; stall_clr = 0; squash_in = 0; end  // R4
         if (cyc == 41 || cyc == 42) begin stall_clr = 0; squash_in = 0; end
         if (cyc == 50 && !dhold) begin     // R3: killed lanes take no slot
            dec_vld = '1; dec_kill = 4'b0101; dec_sb = '0; dec_sa = '0;
         end
         prev_sq = squash_in;
         model_step();
      end
      // R12: the driven traffic stays within the skid capacity
      chk(max_skid <= CAP, "R12", "skid occupancy", max_skid, CAP);
      done = 1;
      summary();
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         summary();
      end
   end
endmodule